// File: doc/BRIEF.md
# Bridge Address-Window Forwarding Decoder

This block sits beside the transaction path of a two-bus bridge. For every address presented to it, it decides whether the bridge should claim the transaction and pass it across. A transaction started on the near (primary) side may be sent downstream. A transaction started on the far (secondary) side may be sent upstream. The decision depends on two programmable address windows and four enable bits. One window covers I/O space and the other covers non-prefetchable memory. The enables are I/O enable, memory enable, bus-master enable and a legacy 10-bit I/O compatibility filter.

When the compatibility filter is on, each aligned 1 KB block of I/O space below the 64 KB boundary is split in two. The low 256 bytes belong to devices on the far side and go downstream, but only if they are also inside the I/O window. The upper 768 bytes stay on the near side and are always sent upstream. Software programs the windows and enables through a small synchronous write port. A request is a single-cycle pulse on `req_valid`, and its two decision bits appear registered on the following cycle.

Top module: `xbus_fwd_decode`

## Requirements
- R1: After synchronous reset, every enable bit is 0 and every window register is 0. `fwd_down` and `fwd_up` are low, and no request is forwarded until software sets the enables.
- R2: A write with `cfg_we`=1 updates one register, selected by `cfg_sel`:
  - 0 selects the control register: bit0 is I/O enable, bit1 is memory enable, bit2 is master enable and bit3 is compatibility filter enable.
  - 1 selects the I/O base and 2 selects the I/O limit.
  - 3 selects the memory base and 4 selects the memory limit.
  - Writes to selects 5, 6 and 7 change nothing.
- R3: The decision for a request sampled at a rising edge appears on the outputs after that edge and is held for one cycle. A cycle with `req_valid`=0 gives both outputs low. A request uses the configuration in effect before any write in the same cycle.
- R4: A near-side I/O request (`req_is_mem`=0, `req_from_sec`=0) is forwarded downstream only when I/O enable is set and base <= addr <= limit. A limit below the base makes the window empty.
- R5: With the filter on, a near-side I/O request below 64 KB (addr[31:16]=0) whose address bits [9:8] are nonzero is never forwarded downstream, even inside the window.
- R6: An I/O address at or above 64 KB is decided by the window alone, whether the filter is on or off.
- R7: A far-side I/O request (`req_from_sec`=1) is forwarded upstream in two cases: when it lies outside the I/O window, or when the filter is on, the address is below 64 KB and bits [9:8] are nonzero.
- R8: No request is forwarded upstream while master enable is 0.
- R9: A near-side memory request (`req_is_mem`=1) is forwarded downstream only when memory enable is set and the address is inside the memory window.
- R10: A far-side memory request is forwarded upstream only when master enable is set and the address is outside the memory window.
- R11: A near-side request never raises `fwd_up`, and a far-side request never raises `fwd_down`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request address |
| req_is_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_from_sec | input | 1 | 1 = initiated on far (secondary) side |
| fwd_down | output | 1 | Registered: forward downstream |
| fwd_up | output | 1 | Registered: forward upstream |

## Verification
The block's internal state is the configuration it holds. A corrupted enable bit or window bound shows up at the outputs on the first request that hits the affected region, one cycle after that request. It stays invisible until such a request arrives. For this reason the stimulus walks each window edge (base-1, base, limit, limit+1), both halves of a 1 KB block on both sides of 64 KB, and every enable in both states. A stale or skewed output register shows up on the next cycle as a decision that answers the previous request.

// File: rtl/xbus_fwd_pkg.sv
package xbus_fwd_pkg;

  typedef struct packed {
    logic isa;
    logic mst;
    logic mem;
    logic io;
  } en_flags_t;

  localparam logic [2:0] SEL_CTRL    = 3'd0;
  localparam logic [2:0] SEL_IO_BASE = 3'd1;
  localparam logic [2:0] SEL_IO_LIM  = 3'd2;
  localparam logic [2:0] SEL_MEM_BASE= 3'd3;
  localparam logic [2:0] SEL_MEM_LIM = 3'd4;

  localparam int NUM_WIN = 2;

endpackage

// File: rtl/xbus_fwd_cfg.sv
module xbus_fwd_cfg
  import xbus_fwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] wdata,
  output en_flags_t         flags,
  output logic [ADDR_W-1:0] win_base [NUM_WIN],
  output logic [ADDR_W-1:0] win_lim  [NUM_WIN]
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (we && sel == SEL_CTRL) begin
      flags <= en_flags_t'(wdata[3:0]);
    end
  end

  // window 0 is I/O, window 1 is memory; selects pair up as base/limit
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [SEL_W-1:0] BASE_SEL = SEL_W'(1 + 2*w);
    localparam logic [SEL_W-1:0] LIM_SEL  = SEL_W'(2 + 2*w);
    always_ff @(posedge clk) begin
      if (rst) begin
        win_base[w] <= '0;
        win_lim[w]  <= '0;
      end else if (we) begin
        if (sel == BASE_SEL) win_base[w] <= wdata;
        if (sel == LIM_SEL)  win_lim[w]  <= wdata;
      end
    end
  end

endmodule

// File: rtl/xbus_fwd_window.sv
module xbus_fwd_window #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] lim,
  output logic              hit
);

  logic above_base;
  logic below_lim;

  always_comb begin
    above_base = (addr >= base);
    below_lim  = (addr <= lim);
    hit        = above_base && below_lim;
  end

endmodule

// File: rtl/xbus_fwd_decide.sv
module xbus_fwd_decide
  import xbus_fwd_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LOW_BITS = 16,
  parameter int BLK_BITS = 10,
  parameter int SUB_BITS = 8
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_mem,
  input  logic              from_sec,
  input  en_flags_t         flags,
  input  logic              io_hit,
  input  logic              mem_hit,
  output logic              down,
  output logic              up
);

  logic below_low;
  logic upper_part;
  logic legacy_far;

  always_comb begin
    below_low  = (addr[ADDR_W-1:LOW_BITS] == '0);
    upper_part = (addr[BLK_BITS-1:SUB_BITS] != '0);
    legacy_far = flags.isa && below_low && upper_part;

    down = 1'b0;
    up   = 1'b0;
    if (valid) begin
      unique case ({is_mem, from_sec})
        2'b00: down = flags.io  && io_hit && !legacy_far;
        2'b01: up   = flags.mst && (legacy_far || !io_hit);
        2'b10: down = flags.mem && mem_hit;
        2'b11: up   = flags.mst && !mem_hit;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/xbus_fwd_decode.sv
module xbus_fwd_decode
  import xbus_fwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_mem,
  input  logic              req_from_sec,
  output logic              fwd_down,
  output logic              fwd_up
);

  en_flags_t         flags;
  logic [ADDR_W-1:0] win_base [NUM_WIN];
  logic [ADDR_W-1:0] win_lim  [NUM_WIN];
  logic [NUM_WIN-1:0] hit;
  logic              dn_c;
  logic              up_c;

  xbus_fwd_cfg #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .flags    (flags),
    .win_base (win_base),
    .win_lim  (win_lim)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    xbus_fwd_window #(.ADDR_W(ADDR_W)) u_win (
      .addr (req_addr),
      .base (win_base[w]),
      .lim  (win_lim[w]),
      .hit  (hit[w])
    );
  end

  xbus_fwd_decide #(.ADDR_W(ADDR_W)) u_dec (
    .valid    (req_valid),
    .addr     (req_addr),
    .is_mem   (req_is_mem),
    .from_sec (req_from_sec),
    .flags    (flags),
    .io_hit   (hit[0]),
    .mem_hit  (hit[1]),
    .down     (dn_c),
    .up       (up_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_down <= 1'b0;
      fwd_up   <= 1'b0;
    end else begin
      fwd_down <= dn_c;
      fwd_up   <= up_c;
    end
  end

endmodule

// File: rtl/xbus_fwd_decode_chk.sv
module xbus_fwd_decode_chk
  import xbus_fwd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_is_mem,
  input logic              req_from_sec,
  input logic              fwd_down,
  input logic              fwd_up,
  input en_flags_t         flags
);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!fwd_down && !fwd_up));

  a_r3_idle_no_fwd: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!fwd_down && !fwd_up));

  a_r11_far_not_down: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_from_sec) |=> !fwd_down);

  a_r11_near_not_up: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_from_sec) |=> !fwd_up);

  a_r5_legacy_block: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_from_sec && !req_is_mem && flags.isa &&
     req_addr[ADDR_W-1:16] == '0 && req_addr[9:8] != 2'b00) |=> !fwd_down);

  a_r8_master_gate: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !flags.mst) |=> !fwd_up);

  a_r9_mem_gate: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_is_mem && !flags.mem) |=> !fwd_down);

  a_r4_io_gate: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_is_mem && !flags.io) |=> !fwd_down);

endmodule

bind xbus_fwd_decode xbus_fwd_decode_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_xbus_fwd_decode.sv
module sim_xbus_fwd_decode;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_is_mem = 1'b0;
  logic        req_from_sec = 1'b0;
  logic        fwd_down;
  logic        fwd_up;

  int errors = 0;
  int checks = 0;

  // reference configuration
  bit  m_io, m_mem, m_mst, m_isa;
  longint m_iob, m_iol, m_mb, m_ml;

  always #5 clk = ~clk;

  xbus_fwd_decode u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_mem(req_is_mem), .req_from_sec(req_from_sec),
    .fwd_down(fwd_down), .fwd_up(fwd_up)
  );

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic void model(input bit v, input longint a, input bit mem,
                                input bit far, output bit ed, output bit eu);
    bit inside_io  = (a >= m_iob) && (a <= m_iol);
    bit inside_mem = (a >= m_mb)  && (a <= m_ml);
    bit legacy     = m_isa && (a < 65536) && ((a % 1024) >= 256);
    ed = 0; eu = 0;
    if (!v) return;
    if (mem) begin
      if (far) eu = m_mst && !inside_mem;
      else     ed = m_mem && inside_mem;
    end else begin
      if (far) eu = m_mst && (legacy || !inside_io);
      else     ed = m_io && inside_io && !legacy;
    end
  endfunction

  task automatic cyc(input bit we, input int sel, input longint wd,
                     input bit v, input longint a, input bit mem, input bit far,
                     input string tag);
    bit ed, eu;
    cfg_we = we; cfg_sel = 3'(sel); cfg_wdata = 32'(wd);
    req_valid = v; req_addr = 32'(a); req_is_mem = mem; req_from_sec = far;
    model(v, a, mem, far, ed, eu);
    @(posedge clk);
    if (we) begin
      case (sel)
        0: begin m_io = wd[0]; m_mem = wd[1]; m_mst = wd[2]; m_isa = wd[3]; end
        1: m_iob = wd & 64'hFFFF_FFFF;
        2: m_iol = wd & 64'hFFFF_FFFF;
        3: m_mb  = wd & 64'hFFFF_FFFF;
        4: m_ml  = wd & 64'hFFFF_FFFF;
        default: ;
      endcase
    end
    @(negedge clk);
    checks++;
    if (fwd_down !== ed || fwd_up !== eu) begin
      errors++;
      $display("FAIL %s addr=%h mem=%0d far=%0d: got down=%0b up=%0b exp down=%0b up=%0b",
               tag, a[31:0], mem, far, fwd_down, fwd_up, ed, eu);
    end
  endtask

  task automatic wr(input int sel, input longint wd, input string tag);
    cyc(1, sel, wd, 0, 0, 0, 0, tag);
  endtask

  initial begin
    m_io = 0; m_mem = 0; m_mst = 0; m_isa = 0;
    m_iob = 0; m_iol = 0; m_mb = 0; m_ml = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, nothing forwarded in any combination
    cyc(0, 0, 0, 1, 0, 0, 0, "R1");
    cyc(0, 0, 0, 1, 0, 1, 0, "R1");
    cyc(0, 0, 0, 1, 'h1234, 0, 1, "R1");
    cyc(0, 0, 0, 1, 'h1234, 1, 1, "R1");
    // R2: unused selects ignored
    wr(5, 'hF, "R2");
    wr(6, 'hF, "R2");
    wr(7, 'hF, "R2");
    cyc(0, 0, 0, 1, 0, 1, 0, "R2");
    cyc(0, 0, 0, 1, 'h10, 1, 1, "R2");
    // configure
    wr(1, 'h1000, "R2");
    wr(2, 'h2_FFFF, "R2");
    wr(3, 'h8000_0000, "R2");
    wr(4, 'h8FFF_FFFF, "R2");
    wr(0, 'h7, "R2");
    // R4: I/O window edges
    cyc(0, 0, 0, 1, 'h0FFF, 0, 0, "R4");
    cyc(0, 0, 0, 1, 'h1000, 0, 0, "R4");
    cyc(0, 0, 0, 1, 'h1300, 0, 0, "R4");
    cyc(0, 0, 0, 1, 'h2_FFFF, 0, 0, "R4");
    cyc(0, 0, 0, 1, 'h3_0000, 0, 0, "R4");
    // R7: far-side I/O without filter
    cyc(0, 0, 0, 1, 'h0FFF, 0, 1, "R7");
    cyc(0, 0, 0, 1, 'h1300, 0, 1, "R7");
    cyc(0, 0, 0, 1, 'h3_0000, 0, 1, "R7");
    // R9 / R10: memory window edges
    cyc(0, 0, 0, 1, 'h7FFF_FFFF, 1, 0, "R9");
    cyc(0, 0, 0, 1, 'h8000_0000, 1, 0, "R9");
    cyc(0, 0, 0, 1, 'h8FFF_FFFF, 1, 0, "R9");
    cyc(0, 0, 0, 1, 'h9000_0000, 1, 0, "R9");
    cyc(0, 0, 0, 1, 'h7FFF_FFFF, 1, 1, "R10");
    cyc(0, 0, 0, 1, 'h8800_0000, 1, 1, "R10");
    cyc(0, 0, 0, 1, 'h9000_0000, 1, 1, "R10");
    // R3: idle cycle, and request in the same cycle as a write uses old config
    cyc(0, 0, 0, 0, 'h1000, 0, 0, "R3");
    cyc(1, 0, 'hF, 1, 'h1300, 0, 0, "R3");
    // R5: filter on, below 64 KB
    cyc(0, 0, 0, 1, 'h1300, 0, 0, "R5");
    cyc(0, 0, 0, 1, 'h1100, 0, 0, "R5");
    cyc(0, 0, 0, 1, 'h10FF, 0, 0, "R5");
    cyc(0, 0, 0, 1, 'h1400, 0, 0, "R5");
    cyc(0, 0, 0, 1, 'hFFFF, 0, 0, "R5");
    // R6: above 64 KB, filter ignored
    cyc(0, 0, 0, 1, 'h1_0300, 0, 0, "R6");
    cyc(0, 0, 0, 1, 'h2_0200, 0, 0, "R6");
    cyc(0, 0, 0, 1, 'h1_0300, 0, 1, "R6");
    // R7: far-side with filter
    cyc(0, 0, 0, 1, 'h1300, 0, 1, "R7");
    cyc(0, 0, 0, 1, 'h1000, 0, 1, "R7");
    cyc(0, 0, 0, 1, 'h0300, 0, 1, "R7");
    cyc(0, 0, 0, 1, 'h0000, 0, 1, "R7");
    // R4: empty window when limit < base
    wr(2, 'h0800, "R4");
    cyc(0, 0, 0, 1, 'h0900, 0, 0, "R4");
    cyc(0, 0, 0, 1, 'h1000, 0, 0, "R4");
    cyc(0, 0, 0, 1, 'h1000, 0, 1, "R4");
    // R8: master off blocks upstream
    wr(0, 'hB, "R8");
    cyc(0, 0, 0, 1, 'h1300, 0, 1, "R8");
    cyc(0, 0, 0, 1, 'h9000_0000, 1, 1, "R8");
    cyc(0, 0, 0, 1, 'h8000_0000, 1, 0, "R9");
    // R9: memory enable off
    wr(0, 'h5, "R9");
    cyc(0, 0, 0, 1, 'h8000_0000, 1, 0, "R9");
    cyc(0, 0, 0, 1, 'h9000_0000, 1, 1, "R10");
    // R11: near never up, far never down (window covers all memory)
    wr(3, 0, "R11");
    wr(4, 'hFFFF_FFFF, "R11");
    wr(0, 'h7, "R11");
    cyc(0, 0, 0, 1, 'h4000_0000, 1, 1, "R11");
    cyc(0, 0, 0, 1, 'h4000_0000, 1, 0, "R11");
    // R1: reset clears configuration again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_io = 0; m_mem = 0; m_mst = 0; m_isa = 0;
    m_iob = 0; m_iol = 0; m_mb = 0; m_ml = 0;
    cyc(0, 0, 0, 1, 'h4000_0000, 1, 1, "R1");
    cyc(0, 0, 0, 1, 0, 1, 0, "R1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule